// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a forward-mapped page table with two levels that lives in ordinary memory. The virtual address is cut into three fields: the top 10 bits pick an entry in the outer table, the next 10 bits pick an entry in the inner table that the outer entry points to, and the low 12 bits pass through as the byte offset inside the page.

Two configuration registers are loaded through a small write port, and only when the write is marked privileged. The first holds the table base, which locates the outer table. The second holds the table length, which bounds the outer index. A requester hands over one address at a time through a valid/ready handshake. The walker then issues up to two reads on a memory read port that allows a single outstanding read. It returns either the physical address or a fault with a two-bit cause code, and holds that result until the requester accepts it.

Top module: `pt_walker`

## Requirements
- R1: For an accepted request whose outer index (vaddr[31:22]) is below the length register, the first memory read goes to table base + outer index × 4.
- R2: The base register (cfg_sel=0) and the length register (cfg_sel=1, data bits 10:0) change only on a cycle with cfg_wr_en and cfg_priv both high. A write with cfg_priv low has no effect.
- R3: An outer index equal to or above the length register gives rsp_fault=1 with cause 0, and the walker issues no memory read.
- R4: An outer entry whose bit 0 (valid) is clear gives rsp_fault=1 with cause 1, and no second read is made.
- R5: After a valid outer entry, the second read goes to {outer entry[31:12], 12'h000} + inner index (vaddr[21:12]) × 4.
- R6: A leaf entry whose bit 0 (valid) is clear gives rsp_fault=1 with cause 2.
- R7: A write request (req_write=1) to a leaf whose bit 1 (writable) is clear gives rsp_fault=1 with cause 3. A read request to the same leaf succeeds.
- R8: A successful walk returns rsp_fault=0 and rsp_paddr = {leaf entry[31:12], vaddr[11:0]}.
- R9: Only one walk runs at a time. req_ready is low from the cycle after a request is accepted until the result has been taken with rsp_ready. rsp_valid and the result fields stay constant while rsp_ready is low.
- R10: While mem_req_valid is high and mem_req_ready is low, the request and its address stay constant. No read is issued while a result is pending.
- R11: After reset, req_ready=1, rsp_valid=0 and mem_req_valid=0. The base and length registers are 0, so every request faults with cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Write is privileged; unprivileged writes are dropped |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the table length |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store (checked against the writable bit) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | Fault cause: 0 length, 1 outer invalid, 2 leaf invalid, 3 write to read-only |

## Verification
An accepted request with a length fault shows rsp_valid one cycle after the accepting edge, with mem_req_valid still low. Otherwise the first read is on mem_req_addr one cycle after acceptance. Each later step appears one cycle after the handshake edge that ends the step before it: the read being taken, the data arriving, the second read being taken, and the leaf data arriving. The bench drives every input at the falling edge and plays memory itself, with stalls of zero to two cycles on each handshake. It checks each output at the falling edge that follows the edge where that output is due, and it checks hold behaviour on every stalled cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OREQ,
      ST_OWAIT,
      ST_IREQ,
      ST_IWAIT,
      ST_DONE
   } walk_st_t;

   typedef enum logic [1:0] {
      FLT_LEN   = 2'd0,
      FLT_OUTER = 2'd1,
      FLT_LEAF  = 2'd2,
      FLT_WPROT = 2'd3
   } flt_t;

   localparam int PTE_V_BIT = 0;
   localparam int PTE_W_BIT = 1;

endpackage

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs #(
   parameter int AW    = 32,
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             priv,
   input  logic             sel,
   input  logic [AW-1:0]    wdata,
   output logic [AW-1:0]    base_q,
   output logic [LEN_W-1:0] len_q
);

   if (LEN_W > AW) begin : g_bad_len
      $error("ptw_cfg_regs: LEN_W wider than data");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
      end else if (wr_en && priv) begin
         if (sel) len_q  <= wdata[LEN_W-1:0];
         else     base_q <= wdata;
      end
   end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W      = 32,
   parameter int OIDX_W    = 10,
   parameter int IIDX_W    = 10,
   parameter int ENT_SH    = 2,
   parameter bit LEN_CHECK = 1'b1
) (
   input  logic [OIDX_W-1:0] chk_oidx,
   input  logic [OIDX_W:0]   len,
   input  logic [OIDX_W-1:0] oidx,
   input  logic [IIDX_W-1:0] iidx,
   input  logic [PA_W-1:0]   base,
   input  logic [PA_W-1:0]   inner_base,
   input  logic              sel_inner,
   output logic [PA_W-1:0]   addr,
   output logic              len_bad
);

   logic [PA_W-1:0] outer_addr;
   logic [PA_W-1:0] inner_addr;

   assign outer_addr = base + (PA_W'(oidx) << ENT_SH);
   assign inner_addr = inner_base + (PA_W'(iidx) << ENT_SH);
   assign addr       = sel_inner ? inner_addr : outer_addr;

   if (LEN_CHECK) begin : g_len_chk
      assign len_bad = ({1'b0, chk_oidx} >= len);
   end else begin : g_len_off
      logic [OIDX_W*2:0] len_unused;
      assign len_unused = {chk_oidx, len};
      assign len_bad    = 1'b0;
   end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import ptw_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int PTE_W = 32,
   parameter int OFF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   input  logic             len_bad,
   output logic             req_ready,
   output logic [VA_W-1:0]  vaddr_q,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic             sel_inner,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic [PA_W-1:0]  inner_base,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fault,
   output logic [1:0]       rsp_cause
);

   localparam int FRM_W = PTE_W - OFF_W;

   walk_st_t         st_q;
   logic             wr_q;
   logic             fault_q;
   flt_t             cause_q;
   logic [PA_W-1:0]  paddr_q;
   logic [FRM_W-1:0] frame;
   logic             pte_v;
   logic             pte_w;
   logic [OFF_W-3:0] pte_unused;

   assign frame      = mem_rsp_data[PTE_W-1:OFF_W];
   assign pte_v      = mem_rsp_data[PTE_V_BIT];
   assign pte_w      = mem_rsp_data[PTE_W_BIT];
   assign pte_unused = mem_rsp_data[OFF_W-1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         vaddr_q    <= '0;
         wr_q       <= 1'b0;
         inner_base <= '0;
         paddr_q    <= '0;
         fault_q    <= 1'b0;
         cause_q    <= FLT_LEN;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  wr_q    <= req_write;
                  if (len_bad) begin
                     fault_q <= 1'b1;
                     cause_q <= FLT_LEN;
                     paddr_q <= '0;
                     st_q    <= ST_DONE;
                  end else begin
                     st_q    <= ST_OREQ;
                  end
               end
            end
            ST_OREQ: if (mem_req_ready) st_q <= ST_OWAIT;
            ST_OWAIT: begin
               if (mem_rsp_valid) begin
                  if (!pte_v) begin
                     fault_q <= 1'b1;
                     cause_q <= FLT_OUTER;
                     paddr_q <= '0;
                     st_q    <= ST_DONE;
                  end else begin
                     inner_base <= {frame, {OFF_W{1'b0}}};
                     st_q       <= ST_IREQ;
                  end
               end
            end
            ST_IREQ: if (mem_req_ready) st_q <= ST_IWAIT;
            ST_IWAIT: begin
               if (mem_rsp_valid) begin
                  st_q <= ST_DONE;
                  if (!pte_v) begin
                     fault_q <= 1'b1;
                     cause_q <= FLT_LEAF;
                     paddr_q <= '0;
                  end else if (wr_q && !pte_w) begin
                     fault_q <= 1'b1;
                     cause_q <= FLT_WPROT;
                     paddr_q <= '0;
                  end else begin
                     fault_q <= 1'b0;
                     cause_q <= FLT_LEN;
                     paddr_q <= {frame, vaddr_q[OFF_W-1:0]};
                  end
               end
            end
            ST_DONE: if (rsp_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_OREQ) || (st_q == ST_IREQ);
   assign sel_inner     = (st_q == ST_IREQ);
   assign rsp_valid     = (st_q == ST_DONE);
   assign rsp_paddr     = paddr_q;
   assign rsp_fault     = fault_q;
   assign rsp_cause     = cause_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int OFF_W     = 12,
   parameter int OIDX_W    = 10,
   parameter bit LEN_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic             cfg_priv,
   input  logic             cfg_sel,
   input  logic [PA_W-1:0]  cfg_wdata,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fault,
   output logic [1:0]       rsp_cause
);

   localparam int IIDX_W = VA_W - OFF_W - OIDX_W;
   localparam int LEN_W  = OIDX_W + 1;
   localparam int ENT_SH = $clog2(PTE_W / 8);

   if (IIDX_W < 1) begin : g_bad_split
      $error("pt_walker: address split leaves no inner index");
   end
   if (PA_W != PTE_W) begin : g_bad_pte
      $error("pt_walker: entry width must equal physical address width");
   end
   if ((PTE_W % 8) != 0 || OFF_W < 2) begin : g_bad_ent
      $error("pt_walker: entry width or offset width unsupported");
   end

   logic [PA_W-1:0]  base_q;
   logic [LEN_W-1:0] len_q;
   logic [VA_W-1:0]  vaddr_q;
   logic [PA_W-1:0]  inner_base;
   logic             sel_inner;
   logic             len_bad;

   ptw_cfg_regs #(.AW(PA_W), .LEN_W(LEN_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .priv   (cfg_priv),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .base_q (base_q),
      .len_q  (len_q)
   );

   ptw_addr_gen #(
      .PA_W(PA_W), .OIDX_W(OIDX_W), .IIDX_W(IIDX_W),
      .ENT_SH(ENT_SH), .LEN_CHECK(LEN_CHECK)
   ) u_agen (
      .chk_oidx   (req_vaddr[VA_W-1 -: OIDX_W]),
      .len        (len_q),
      .oidx       (vaddr_q[VA_W-1 -: OIDX_W]),
      .iidx       (vaddr_q[OFF_W +: IIDX_W]),
      .base       (base_q),
      .inner_base (inner_base),
      .sel_inner  (sel_inner),
      .addr       (mem_req_addr),
      .len_bad    (len_bad)
   );

   ptw_fsm #(.VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .OFF_W(OFF_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_vaddr     (req_vaddr),
      .req_write     (req_write),
      .len_bad       (len_bad),
      .req_ready     (req_ready),
      .vaddr_q       (vaddr_q),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .sel_inner     (sel_inner),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .inner_base    (inner_base),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_paddr     (rsp_paddr),
      .rsp_fault     (rsp_fault),
      .rsp_cause     (rsp_cause)
   );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int OIDX_W    = 10,
   parameter bit LEN_CHECK = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            rsp_valid,
   input logic            rsp_ready,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_fault,
   input logic [1:0]      rsp_cause,
   input logic [OIDX_W:0] len_q
);

   logic [OFF_W-1:0] off_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                      off_q <= '0;
      else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
   end

   AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready); // R9

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
         && $stable(rsp_fault) && $stable(rsp_cause))); // R9

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

   AST_NO_READ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_req_valid); // R10

   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_q)); // R8

   if (LEN_CHECK) begin : g_len
      AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1 -: OIDX_W]} >= len_q))
         |=> (rsp_valid && rsp_fault && rsp_cause == 2'd0 && !mem_req_valid)); // R3
   end

endmodule

bind pt_walker pt_walker_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .OIDX_W(OIDX_W), .LEN_CHECK(LEN_CHECK)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_vaddr     (req_vaddr),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_paddr     (rsp_paddr),
   .rsp_fault     (rsp_fault),
   .rsp_cause     (rsp_cause),
   .len_q         (len_q)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam logic [31:0] OBASE = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en, cfg_priv, cfg_sel;
   logic [31:0] cfg_wdata;
   logic        req_valid, req_ready, req_write;
   logic [31:0] req_vaddr;
   logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
   logic [31:0] mem_req_addr, mem_rsp_data;
   logic        rsp_valid, rsp_ready, rsp_fault;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_cause;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 0;
   int   len_m  = 0;
   logic [31:0] base_m = 32'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_walker u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] outer_pte(input int i);
      logic v = ((i % 5) != 3);
      return ((32'h400 + i) << 12) | {30'd0, 1'b1, v};
   endfunction

   function automatic logic [31:0] leaf_pte(input int i, input int j);
      logic v = (((i + j) % 7) != 0);
      logic w = ((j % 3) != 0);
      logic [19:0] f = 20'((i * 37 + j * 11 + 5) & 32'hFFFFF);
      return {f, 10'd0, w, v};
   endfunction

   function automatic logic [31:0] mem_data(input logic [31:0] a);
      if (a >= 32'h0040_0000) return leaf_pte(int'((a >> 12) - 32'h400), int'((a >> 2) & 32'h3FF));
      else return outer_pte(int'((a - OBASE) >> 2));
   endfunction

   task automatic cfg_write(input bit priv, input bit sel, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1; cfg_priv = priv; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 0; cfg_priv = 0;
      if (priv) begin
         if (sel) len_m = int'(d[10:0]);
         else     base_m = d;
      end
   endtask

   // one memory read: stall lat cycles, take it, return data after lat cycles
   task automatic mem_serve(input int lat, input string tag);
      logic [31:0] a = mem_req_addr;
      for (int k = 0; k < lat; k++) begin
         @(negedge clk);
         chk(mem_req_valid && mem_req_addr == a, {tag, " R10 hold"}, mem_req_addr, a);
      end
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      chk(!mem_req_valid, {tag, " R10 one read"}, {31'd0, mem_req_valid}, 0);
      for (int k = 0; k < lat; k++) @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_data = mem_data(a);
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
   endtask

   task automatic take_rsp(input int lat, input bit ef, input logic [1:0] ec,
                           input logic [31:0] ep, input string tag);
      chk(rsp_valid === 1'b1, {tag, " R9 rsp_valid"}, {31'd0, rsp_valid}, 1);
      chk(rsp_fault === ef, {tag, " fault"}, {31'd0, rsp_fault}, {31'd0, ef});
      chk(rsp_cause === ec || !ef, {tag, " cause"}, {30'd0, rsp_cause}, {30'd0, ec});
      chk(ef || rsp_paddr === ep, {tag, " R8 paddr"}, rsp_paddr, ep);
      for (int k = 0; k < lat; k++) begin
         @(negedge clk);
         chk(rsp_valid && !req_ready && rsp_paddr === (ef ? rsp_paddr : ep),
             "R9 result held", {31'd0, rsp_valid}, 1);
      end
      rsp_ready = 1;
      @(negedge clk);
      rsp_ready = 0;
      chk(!rsp_valid && req_ready, "R9 back to idle", {31'd0, req_ready}, 1);
   endtask

   task automatic walk(input int oi, input int ii, input int off, input bit wr, input int lat);
      logic [31:0] va = {10'(oi), 10'(ii), 12'(off)};
      logic [31:0] ope = outer_pte(oi);
      logic [31:0] lpe = leaf_pte(oi, ii);
      @(negedge clk);
      chk(req_ready === 1'b1, "R9 ready before request", {31'd0, req_ready}, 1);
      req_valid = 1; req_vaddr = va; req_write = wr;
      @(negedge clk);
      req_valid = 0;
      chk(req_ready === 1'b0, "R9 busy after accept", {31'd0, req_ready}, 0);
      if (oi >= len_m) begin
         chk(!mem_req_valid, "R3 no read on length fault", {31'd0, mem_req_valid}, 0);
         take_rsp(lat, 1, 2'd0, 0, "R3");
         return;
      end
      chk(mem_req_valid && mem_req_addr == base_m + 32'(oi) * 4, "R1 outer address",
          mem_req_addr, base_m + 32'(oi) * 4);
      mem_serve(lat, "outer");
      if (!ope[0]) begin
         chk(!mem_req_valid, "R4 no second read", {31'd0, mem_req_valid}, 0);
         take_rsp(lat, 1, 2'd1, 0, "R4");
         return;
      end
      chk(mem_req_valid && mem_req_addr == ((32'h400 + 32'(oi)) << 12) + 32'(ii) * 4,
          "R5 inner address", mem_req_addr, ((32'h400 + 32'(oi)) << 12) + 32'(ii) * 4);
      mem_serve(lat, "inner");
      if (!lpe[0])            take_rsp(lat, 1, 2'd2, 0, "R6");
      else if (wr && !lpe[1]) take_rsp(lat, 1, 2'd3, 0, "R7");
      else                    take_rsp(lat, 0, 2'd0, {lpe[31:12], 12'(off)}, "R8");
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cfg_wr_en = 0; cfg_priv = 0; cfg_sel = 0; cfg_wdata = 0;
      req_valid = 0; req_vaddr = 0; req_write = 0;
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; rsp_ready = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R11 req_ready", {31'd0, req_ready}, 1);
      chk(rsp_valid === 1'b0, "R11 rsp_valid", {31'd0, rsp_valid}, 0);
      chk(mem_req_valid === 1'b0, "R11 mem_req_valid", {31'd0, mem_req_valid}, 0);
      walk(0, 0, 0, 0, 0);                         // R11: length 0 faults everything

      cfg_write(0, 0, OBASE);                      // R2: dropped
      cfg_write(0, 1, 32'd600);                    // R2: dropped
      walk(0, 5, 12, 0, 1);                        // still length fault
      cfg_write(1, 0, OBASE);
      cfg_write(1, 1, 32'd600);
      walk(0, 1, 32'h123, 0, 0);                   // R2 now walks
      cfg_write(0, 0, 32'h0BAD_0000);              // R2: dropped, base kept
      walk(1, 2, 32'hABC, 0, 2);

      for (int oi = 0; oi < 1024; oi += 7)
         for (int k = 0; k < 4; k++)
            walk(oi, (oi * 13 + k * 251) % 1024, (oi * 97 + k * 1111) & 12'hFFF, k[0], k % 3);

      walk(599, 0, 1, 0, 0);                       // last index inside length
      walk(600, 0, 1, 0, 0);                       // R3 boundary
      walk(1023, 1023, 32'hFFF, 1, 1);
      walk(2, 3, 7, 1, 0);                         // R7: j%3==0 read-only, write
      walk(2, 3, 7, 0, 0);                         // R7: same page read passes
      cfg_write(1, 1, 32'd1024);
      walk(1022, 1023, 32'hFFF, 0, 1);
      walk(1023, 0, 0, 0, 0);                      // R4 outer invalid at top index

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule